// File: doc/BRIEF.md
# Interrupt Acceptance and Global Enable Control

This block decides, at every instruction boundary of a simple in-order core, whether an interrupt is taken and which source gets it. It holds the global interrupt flag. It watches a strobe that marks each retiring instruction, together with that instruction's decoded kind: enable-all, disable-all, return-from-handler, or anything else. When an interrupt is accepted it raises a one-cycle take strobe and a registered source index. The front end then redirects fetch to the handler.

Enabling is deliberately lazy and disabling is eager. The enable-all instruction and the return instruction turn the global flag on, but the boundary right after them never accepts. At least one more instruction therefore retires first. This guarantees progress of the interrupted code under a steady stream of requests. The disable-all instruction closes the gate at its own boundary, so the pair enable-then-disable opens no window at all.

The requests are level-sensitive. A request that is still high when its handler returns competes again at the next open boundary. The lowest-numbered enabled source always wins.

Top module: `irq_accept`

## Requirements
- R1: While `rst` is high at a clock edge, the design clears `gie` and `take` after that edge and sets `take_idx` to 0.
- R2: When an instruction with `op_set` retires, `gie` reads 1 after that edge and `take` stays 0. If a request is pending, the next retiring instruction produces a take.
- R3: When an instruction with `op_clr` retires, `gie` reads 0 after that edge and `take` stays 0, even when a request first appears in that same cycle.
- R4: An `op_set` instruction followed directly by an `op_clr` instruction yields no take at either boundary, and `gie` ends at 0.
- R5: When an instruction with `op_ret` retires, `gie` reads 1 after that edge and `take` stays 0. At least one further instruction retires before the next take.
- R6: Among the sources that have both `irq_req` and `irq_en` set, `take_idx` reports the lowest bit index.
- R7: A source whose `irq_en` bit is 0 is never taken. When no request is enabled, the design produces no take and `gie` stays 1.
- R8: A take clears `gie` on the same edge. `take` is high for exactly one cycle, and `take_idx` holds its value until the next take.
- R9: In a cycle with `retire` low, the design produces no take and `gie` keeps its value, even with enabled requests pending.
- R10: A request still asserted after its handler returns wins again at the next open boundary. A lower-priority pending source keeps waiting while that happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire | input | 1 | An instruction retires this cycle |
| op_set | input | 1 | Retiring instruction is enable-all |
| op_clr | input | 1 | Retiring instruction is disable-all |
| op_ret | input | 1 | Retiring instruction is return-from-handler |
| irq_req | input | N_SRC | Level-sensitive request per source, bit i is source i |
| irq_en | input | N_SRC | Per-source enable, bit i is source i |
| take | output | 1 | One-cycle strobe: interrupt accepted at the last boundary |
| take_idx | output | IDX_W | Index of the accepted source |
| gie | output | 1 | Current global interrupt flag |

## Verification
The bound checker evaluates the local rules on every cycle. These are: no take at a boundary of an enable, disable or return instruction; a take always clears the flag and lasts one cycle; an idle cycle changes nothing; and the reported index names an enabled, pending source with no enabled, pending source below it. The window rules depend on sequences of instructions, and only the directed scenarios can show them. These include enable immediately followed by disable, the single instruction that must retire after a return, and a level request that starves a lower source across repeated returns.

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire,
  input  logic             op_set,
  input  logic             op_clr,
  input  logic             op_ret,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_en,
  output logic             take,
  output logic [IDX_W-1:0] take_idx,
  output logic             gie
);

  logic [N_SRC-1:0] live;
  logic [IDX_W-1:0] win;
  logic             quiet_op;
  logic             accept;

  assign live     = irq_req & irq_en;
  assign quiet_op = ~(op_set | op_clr | op_ret);
  assign accept   = retire & gie & quiet_op & (|live);

  always_comb begin
    win = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (live[i]) win = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie      <= 1'b0;
      take     <= 1'b0;
      take_idx <= '0;
    end else begin
      take <= accept;
      if (accept) begin
        gie      <= 1'b0;
        take_idx <= win;
      end else if (retire) begin
        if (op_clr)
          gie <= 1'b0;
        else if (op_set | op_ret)
          gie <= 1'b1;
      end
    end
  end

endmodule

module irq_accept_chk #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             retire,
  input logic             op_set,
  input logic             op_clr,
  input logic             op_ret,
  input logic [N_SRC-1:0] irq_req,
  input logic [N_SRC-1:0] irq_en,
  input logic             take,
  input logic [IDX_W-1:0] take_idx,
  input logic             gie
);

  logic [N_SRC-1:0] sel_bit;
  logic [N_SRC-1:0] below;
  assign sel_bit = N_SRC'(1) << take_idx;
  assign below   = sel_bit - N_SRC'(1);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!take && !gie)); // R1
  AST_SET_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    (retire && op_set && !op_clr) |=> (gie && !take)); // R2
  AST_CLR_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (retire && op_clr) |=> (!gie && !take)); // R3
  AST_RET_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    (retire && op_ret && !op_clr) |=> (gie && !take)); // R5
  AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (rst)
    take |-> (($past(irq_req & irq_en) & below) == '0)); // R6
  AST_SRC_ENABLED: assert property (@(posedge clk) disable iff (rst)
    take |-> (|($past(irq_req & irq_en) & sel_bit))); // R7
  AST_TAKE_MASKS: assert property (@(posedge clk) disable iff (rst)
    take |-> !gie); // R8
  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    take |=> !take); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !retire |=> (!take && $stable(gie))); // R9

endmodule

bind irq_accept irq_accept_chk #(.N_SRC(N_SRC)) chk_i (
  .clk(clk), .rst(rst), .retire(retire), .op_set(op_set), .op_clr(op_clr),
  .op_ret(op_ret), .irq_req(irq_req), .irq_en(irq_en), .take(take),
  .take_idx(take_idx), .gie(gie)
);

// File: tb/irq_accept_tb.sv
module irq_accept_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_SRC = 8;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic retire = 1'b0, op_set = 1'b0, op_clr = 1'b0, op_ret = 1'b0;
  logic [N_SRC-1:0] irq_req = '0, irq_en = '0;
  logic take, gie;
  logic [IDX_W-1:0] take_idx;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_accept #(.N_SRC(N_SRC)) dut_i (
    .clk(clk), .rst(rst), .retire(retire), .op_set(op_set), .op_clr(op_clr),
    .op_ret(op_ret), .irq_req(irq_req), .irq_en(irq_en), .take(take),
    .take_idx(take_idx), .gie(gie)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic instr(input logic s, input logic c, input logic r);
    retire = 1'b1; op_set = s; op_clr = c; op_ret = r;
    @(negedge clk);
    retire = 1'b0; op_set = 1'b0; op_clr = 1'b0; op_ret = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(); idle();
    check("R1 gie", gie, 0);
    check("R1 take", take, 0);
    check("R1 take_idx", take_idx, 0);
    rst = 1'b0;
  endtask

  task automatic t_set();
    irq_en = 8'hFF; irq_req = 8'b0000_0100;
    instr(1, 0, 0);
    check("R2 gie after set", gie, 1);
    check("R2 no take at set", take, 0);
    instr(0, 0, 0);
    check("R2 take after next", take, 1);
    check("R2 idx", take_idx, 2);
    check("R8 gie cleared", gie, 0);
    instr(0, 0, 0);
    check("R8 one cycle", take, 0);
    check("R8 idx held", take_idx, 2);
  endtask

  task automatic t_set_clr();
    instr(1, 0, 0);
    instr(0, 1, 0);
    check("R4 no take", take, 0);
    check("R4 gie", gie, 0);
    instr(0, 0, 0);
    check("R4 still no take", take, 0);
  endtask

  task automatic t_clr();
    irq_req = '0;
    instr(1, 0, 0);
    instr(0, 0, 0);
    check("R3 setup gie", gie, 1);
    irq_req = 8'b0000_0001;
    instr(0, 1, 0);
    check("R3 no take", take, 0);
    check("R3 gie", gie, 0);
  endtask

  task automatic t_ret();
    irq_req = 8'b0010_0000;
    instr(0, 0, 1);
    check("R5 gie after ret", gie, 1);
    check("R5 no take at ret", take, 0);
    instr(0, 0, 0);
    check("R5 take", take, 1);
    check("R5 idx", take_idx, 5);
  endtask

  task automatic t_prio();
    irq_req = 8'b0110_1000; irq_en = 8'hFF;
    instr(0, 0, 1); instr(0, 0, 0);
    check("R6 take", take, 1);
    check("R6 lowest idx", take_idx, 3);
    irq_en = 8'b1111_0111;
    instr(0, 0, 1); instr(0, 0, 0);
    check("R7 masked skipped", take_idx, 5);
    irq_req = 8'b0000_0010; irq_en = 8'b1111_1101;
    instr(0, 0, 1); instr(0, 0, 0);
    check("R7 no take", take, 0);
    instr(0, 0, 0);
    check("R7 still no take", take, 0);
    check("R7 gie kept", gie, 1);
  endtask

  task automatic t_noretire();
    irq_en = 8'hFF;
    for (int k = 0; k < 3; k++) begin
      idle();
      check("R9 no take", take, 0);
      check("R9 gie", gie, 1);
    end
    instr(0, 0, 0);
    check("R9 take on retire", take, 1);
    check("R9 idx", take_idx, 1);
  endtask

  task automatic t_level();
    irq_req = 8'b0001_0001;
    for (int k = 0; k < 3; k++) begin
      instr(0, 0, 1);
      check("R10 no take at ret", take, 0);
      instr(0, 0, 0);
      check("R10 take", take, 1);
      check("R10 high src wins", take_idx, 0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_set();
    t_set_clr();
    t_clr();
    t_ret();
    t_prio();
    t_noretire();
    t_level();
    summary();
  end
endmodule